// File: doc/BRIEF.md
# Serial Time-Slot Assignment Loader

This block is the control-side front end of a time-slot assigner for a PCM bus. Software sends it an 8-bit command one bit at a time on a serial data pin. A framing select is held low while the bits are sent, and the data is taken on each falling edge of a slow control clock. When the select goes high again, the block decodes the command together with a parallel channel-select bus. It then updates a bank of per-channel assignment registers. Each register holds a valid flag and a 5-bit slot number, and a downstream frame-sync generator compares these against its slot counters.

There are two modes. In the four-channel mode, each channel has one transmit register and one receive register, and the two leading command bits say which of them are written. In the eight-channel mode, all eight registers belong to the transmit frame. The command then either assigns a slot to the selected register or disables it. All control inputs are sampled on a single system clock. The control clock and the select are edge-detected in that clock domain, so the register outputs change exactly one system-clock edge after the select's rising edge is seen.

Top module: `tsl_loader`

## Requirements
- R1: After a synchronous reset every transmit and receive valid flag reads 0. The slot fields are only meaningful while their flag is 1.
- R2: The command is 8 bits and is sent most-significant first. Bit 7 is the transmit-enable bit X, bit 6 is the receive-enable bit R, bit 5 is the out-of-range bit, and bits 4..0 are the slot number. A bit is taken on each falling edge of `ctl_clk` seen while `ctl_csn` is low.
- R3: A command takes effect only on a rising edge of `ctl_csn`. The outputs keep their old values until the system-clock edge that first sees `ctl_csn` high after low, and they show the new values right after that edge.
- R4: With `mode_8ch`=0, `ch_sel[1:0]` picks channel 0..3. X=1,R=1 writes both the transmit and receive entries of that channel. X=1,R=0 writes the transmit entry only. X=0,R=1 writes the receive entry only. X=0,R=0 clears both valid flags. Entries that are not named are left unchanged.
- R5: With `mode_8ch`=1, `ch_sel[2:0]` picks transmit entry 0..7. X=1 assigns the slot and X=0 clears the valid flag. R has no effect, and the receive bank is never written.
- R6: A write whose bit 5 is 1 leaves the written entry with its valid flag at 0.
- R7: If the number of bits shifted in before `ctl_csn` rises is not exactly 8 (fewer or more), no register changes.
- R8: Falling edges of `ctl_clk` while `ctl_csn` is high are ignored, and the bit count restarts each time `ctl_csn` is high.
- R9: In the four-channel mode, `ch_sel[2]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_8ch | input | 1 | 0: four channels with transmit and receive; 1: eight transmit channels |
| ctl_clk | input | 1 | Serial control clock; data taken on its falling edge |
| ctl_csn | input | 1 | Active-low framing select; rising edge commits |
| ctl_din | input | 1 | Serial command data |
| ch_sel | input | 3 | Parallel channel select |
| tx_valid | output | 8 | Valid flag per transmit entry |
| tx_slot | output | 40 | Slot number per transmit entry, entry i in bits 5i+4..5i |
| rx_valid | output | 4 | Valid flag per receive entry |
| rx_slot | output | 20 | Slot number per receive entry, entry i in bits 5i+4..5i |

## Verification
Some rules are checked by the assertions on every cycle. Both banks are cleared by reset. The bit counter is clear whenever the select is high. At most one entry per bank is written in a cycle. No write happens unless the select has just risen. The receive bank is never written in eight-channel mode. A register never changes without a write strobe.

Other behaviour only the directed scenarios can show. These are the command decode per mode (which entries change and to what), the bit order, the out-of-range disable, and rejection of short and long words. They also cover the ignoring of the upper channel bit and of stray clock edges, and the exact cycle at which the outputs change.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int unsigned SLOT_W = 5;
  localparam int unsigned WORD_W = SLOT_W + 3;

  typedef struct packed {
    logic              x_en;
    logic              r_en;
    logic              over;
    logic [SLOT_W-1:0] slot;
  } ctl_word_t;
endpackage

// File: rtl/tsl_shift.sv
module tsl_shift #(
  parameter int unsigned WORD_W = tsl_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_clk,
  input  logic              ctl_csn,
  input  logic              ctl_din,
  output logic [WORD_W-1:0] word,
  output logic              commit
);
  localparam int unsigned CNT_W   = $clog2(WORD_W + 2);
  localparam int unsigned CNT_MAX = WORD_W + 1;

  logic             sclk_q;
  logic             csn_q;
  logic [CNT_W-1:0] cnt;
  logic             fall;

  assign fall   = sclk_q && !ctl_clk && !ctl_csn;
  assign commit = !csn_q && ctl_csn && (cnt == CNT_W'(WORD_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      cnt    <= '0;
      word   <= '0;
    end else begin
      sclk_q <= ctl_clk;
      csn_q  <= ctl_csn;
      if (ctl_csn)
        cnt <= '0;
      else if (fall && cnt != CNT_W'(CNT_MAX))
        cnt <= cnt + 1'b1;
      if (fall)
        word <= {word[WORD_W-2:0], ctl_din};
    end
  end

  // R8
  csn_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_csn |=> (cnt == '0));

  // R3
  commit_edge_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> (ctl_csn && !$past(ctl_csn)));
endmodule

// File: rtl/tsl_decode.sv
module tsl_decode #(
  parameter int unsigned NTX = 8,
  parameter int unsigned NRX = 4,
  localparam int unsigned CH_W = $clog2(NTX),
  localparam int unsigned RX_W = $clog2(NRX)
) (
  input  logic                          mode_8ch,
  input  logic                          commit,
  input  tsl_pkg::ctl_word_t            cmd,
  input  logic [CH_W-1:0]               ch,
  output logic [NTX-1:0]                tx_we,
  output logic [NRX-1:0]                rx_we,
  output logic                          tx_val,
  output logic                          rx_val,
  output logic [tsl_pkg::SLOT_W-1:0]    wslot
);
  logic            slot_ok;
  logic            tx_wr;
  logic            rx_wr;
  logic [CH_W-1:0] tx_idx;
  logic [RX_W-1:0] rx_idx;

  assign slot_ok = !cmd.over;
  assign wslot   = cmd.slot;
  assign rx_idx  = ch[RX_W-1:0];

  always_comb begin
    if (mode_8ch) begin
      tx_idx = ch;
      tx_wr  = 1'b1;
      rx_wr  = 1'b0;
      tx_val = cmd.x_en && slot_ok;
      rx_val = 1'b0;
    end else begin
      tx_idx = CH_W'(rx_idx);
      tx_wr  = cmd.x_en || !cmd.r_en;
      rx_wr  = cmd.r_en || !cmd.x_en;
      tx_val = cmd.x_en && slot_ok;
      rx_val = cmd.r_en && slot_ok;
    end
  end

  for (genvar i = 0; i < NTX; i++) begin : g_txwe
    assign tx_we[i] = commit && tx_wr && (tx_idx == CH_W'(i));
  end
  for (genvar i = 0; i < NRX; i++) begin : g_rxwe
    assign rx_we[i] = commit && rx_wr && (rx_idx == RX_W'(i));
  end
endmodule

// File: rtl/tsl_regbank.sv
module tsl_regbank #(
  parameter int unsigned N      = 8,
  parameter int unsigned SLOT_W = tsl_pkg::SLOT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        we,
  input  logic                wval,
  input  logic [SLOT_W-1:0]   wslot,
  output logic [N-1:0]        valid,
  output logic [N*SLOT_W-1:0] slot
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        valid[i]                 <= 1'b0;
        slot[i*SLOT_W +: SLOT_W] <= '0;
      end else if (we[i]) begin
        valid[i]                 <= wval;
        slot[i*SLOT_W +: SLOT_W] <= wslot;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (valid == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (we == '0) |=> ($stable(valid) && $stable(slot)));

  // R4
  single_we_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we));
endmodule

// File: rtl/tsl_loader.sv
module tsl_loader #(
  parameter int unsigned NTX = 8,
  parameter int unsigned NRX = 4,
  localparam int unsigned SW   = tsl_pkg::SLOT_W,
  localparam int unsigned CH_W = $clog2(NTX)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_8ch,
  input  logic               ctl_clk,
  input  logic               ctl_csn,
  input  logic               ctl_din,
  input  logic [CH_W-1:0]    ch_sel,
  output logic [NTX-1:0]     tx_valid,
  output logic [NTX*SW-1:0]  tx_slot,
  output logic [NRX-1:0]     rx_valid,
  output logic [NRX*SW-1:0]  rx_slot
);
  logic [tsl_pkg::WORD_W-1:0] word;
  logic                       commit;
  logic [NTX-1:0]             tx_we;
  logic [NRX-1:0]             rx_we;
  logic                       tx_val;
  logic                       rx_val;
  logic [SW-1:0]              wslot;

  tsl_shift #(.WORD_W(tsl_pkg::WORD_W)) u_shift (
    .clk(clk), .rst(rst), .ctl_clk(ctl_clk), .ctl_csn(ctl_csn),
    .ctl_din(ctl_din), .word(word), .commit(commit)
  );

  tsl_decode #(.NTX(NTX), .NRX(NRX)) u_dec (
    .mode_8ch(mode_8ch), .commit(commit), .cmd(word), .ch(ch_sel),
    .tx_we(tx_we), .rx_we(rx_we), .tx_val(tx_val), .rx_val(rx_val),
    .wslot(wslot)
  );

  tsl_regbank #(.N(NTX), .SLOT_W(SW)) u_tx (
    .clk(clk), .rst(rst), .we(tx_we), .wval(tx_val), .wslot(wslot),
    .valid(tx_valid), .slot(tx_slot)
  );

  tsl_regbank #(.N(NRX), .SLOT_W(SW)) u_rx (
    .clk(clk), .rst(rst), .we(rx_we), .wval(rx_val), .wslot(wslot),
    .valid(rx_valid), .slot(rx_slot)
  );

  // R5
  rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mode_8ch |=> $stable(rx_valid) && $stable(rx_slot));

  // R3
  write_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((tx_we != '0) || (rx_we != '0)) |-> (ctl_csn && !$past(ctl_csn)));
endmodule

// File: tb/sim_tsl_loader.sv
module sim_tsl_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_8ch = 1'b0;
  logic        ctl_clk = 1'b1;
  logic        ctl_csn = 1'b1;
  logic        ctl_din = 1'b0;
  logic [2:0]  ch_sel = 3'd0;
  logic [7:0]  tx_valid;
  logic [39:0] tx_slot;
  logic [3:0]  rx_valid;
  logic [19:0] rx_slot;

  int checks = 0;
  int errors = 0;

  logic [7:0]  e_txv;
  logic [39:0] e_txs;
  logic [3:0]  e_rxv;
  logic [19:0] e_rxs;

  always #4 clk = ~clk;

  tsl_loader u0 (
    .clk(clk), .rst(rst), .mode_8ch(mode_8ch), .ctl_clk(ctl_clk),
    .ctl_csn(ctl_csn), .ctl_din(ctl_din), .ch_sel(ch_sel),
    .tx_valid(tx_valid), .tx_slot(tx_slot), .rx_valid(rx_valid),
    .rx_slot(rx_slot)
  );

  function automatic logic [39:0] mask_tx(input logic [39:0] s, input logic [7:0] v);
    logic [39:0] r = '0;
    for (int i = 0; i < 8; i++) if (v[i]) r[i*5 +: 5] = s[i*5 +: 5];
    return r;
  endfunction

  function automatic logic [19:0] mask_rx(input logic [19:0] s, input logic [3:0] v);
    logic [19:0] r = '0;
    for (int i = 0; i < 4; i++) if (v[i]) r[i*5 +: 5] = s[i*5 +: 5];
    return r;
  endfunction

  task automatic check_all(input string tag);
    logic [39:0] a_t, x_t;
    logic [19:0] a_r, x_r;
    a_t = mask_tx(tx_slot, tx_valid);
    x_t = mask_tx(e_txs, e_txv);
    a_r = mask_rx(rx_slot, rx_valid);
    x_r = mask_rx(e_rxs, e_rxv);
    checks++;
    if (tx_valid !== e_txv || rx_valid !== e_rxv || a_t !== x_t || a_r !== x_r) begin
      errors++;
      $display("FAIL %s: actual txv=%h rxv=%h txs=%h rxs=%h expected txv=%h rxv=%h txs=%h rxs=%h",
               tag, tx_valid, rx_valid, a_t, a_r, e_txv, e_rxv, x_t, x_r);
    end
  endtask

  task automatic model(input logic [7:0] w, input logic [2:0] ch, input logic m);
    logic x, r, ok;
    logic [4:0] s;
    logic [1:0] c;
    x = w[7]; r = w[6]; ok = !w[5]; s = w[4:0]; c = ch[1:0];
    if (m) begin
      e_txv[ch] = x && ok;
      e_txs[ch*5 +: 5] = s;
    end else begin
      if (x || !r) begin e_txv[c] = x && ok; e_txs[c*5 +: 5] = s; end
      if (r || !x) begin e_rxv[c] = r && ok; e_rxs[c*5 +: 5] = s; end
    end
  endtask

  // Shifts nbits bits MSB first, then raises the select and checks the commit cycle.
  task automatic send(input logic [7:0] w, input int nbits, input logic [2:0] ch,
                      input logic m, input string tag);
    logic [7:0] sh;
    sh = w;
    @(negedge clk);
    mode_8ch = m; ch_sel = ch; ctl_csn = 1'b0;
    repeat (2) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      ctl_din = sh[7];
      sh = {sh[6:0], 1'b0};
      ctl_clk = 1'b1;
      repeat (2) @(negedge clk);
      ctl_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    ctl_clk = 1'b1;
    repeat (2) @(negedge clk);
    ctl_csn = 1'b1;
    check_all({tag, " R3 before commit edge"});
    @(posedge clk);
    #1;
    if (nbits == 8) model(w, ch, m);
    check_all(tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    e_txv = '0; e_txs = '0; e_rxv = '0; e_rxs = '0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 during reset");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R1 after reset");
  endtask

  task automatic t_mode1;
    send({2'b11, 1'b0, 5'd21}, 8, 3'd0, 1'b0, "R4 both ch0 R2");
    send({2'b10, 1'b0, 5'd10}, 8, 3'd1, 1'b0, "R4 tx only ch1");
    send({2'b01, 1'b0, 5'd31}, 8, 3'd2, 1'b0, "R4 rx only ch2");
    send({2'b11, 1'b0, 5'd7},  8, 3'd3, 1'b0, "R4 both ch3");
    send({2'b10, 1'b0, 5'd1},  8, 3'd3, 1'b0, "R4 tx only keeps rx ch3");
    send({2'b00, 1'b0, 5'd9},  8, 3'd0, 1'b0, "R4 disable ch0");
  endtask

  task automatic t_over;
    send({2'b11, 1'b1, 5'd4}, 8, 3'd3, 1'b0, "R6 bit5 both ch3");
    send({2'b01, 1'b1, 5'd2}, 8, 3'd2, 1'b0, "R6 bit5 rx ch2");
  endtask

  task automatic t_mode2;
    for (int i = 0; i < 8; i++)
      send({1'b1, i[0], 1'b0, 5'(3 * i + 1)}, 8, 3'(i), 1'b1, "R5 assign 8ch");
    send({2'b01, 1'b0, 5'd12}, 8, 3'd6, 1'b1, "R5 X=0 disables");
    send({2'b00, 1'b0, 5'd12}, 8, 3'd5, 1'b1, "R5 X=0 R=0 disables");
    send({2'b11, 1'b1, 5'd12}, 8, 3'd7, 1'b1, "R6 bit5 in 8ch");
  endtask

  task automatic t_count;
    send({2'b11, 1'b0, 5'd30}, 7, 3'd1, 1'b0, "R7 seven bits");
    send({2'b11, 1'b0, 5'd30}, 9, 3'd1, 1'b0, "R7 nine bits");
    send(8'h00, 0, 3'd1, 1'b0, "R7 zero bits");
  endtask

  task automatic t_idle_edges;
    @(negedge clk);
    ctl_csn = 1'b1; ctl_din = 1'b1;
    for (int k = 0; k < 8; k++) begin
      ctl_clk = 1'b1; repeat (2) @(negedge clk);
      ctl_clk = 1'b0; repeat (2) @(negedge clk);
    end
    ctl_clk = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R8 edges with select high");
    send(8'h00, 0, 3'd1, 1'b0, "R8 no carried bits");
    send({2'b10, 1'b0, 5'd17}, 8, 3'd1, 1'b0, "R8 clean word after stray edges");
  endtask

  task automatic t_ch2;
    send({2'b11, 1'b0, 5'd26}, 8, 3'd6, 1'b0, "R9 ch2 ignored selects ch2");
    send({2'b01, 1'b0, 5'd5},  8, 3'd4, 1'b0, "R9 ch2 ignored selects ch0");
  endtask

  initial begin
    t_reset();
    t_mode1();
    t_over();
    t_count();
    t_idle_edges();
    t_ch2();
    t_mode2();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule